// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit sits beside the integer ALU of a 32-bit RISC-V core and executes the basic bit-manipulation group and the address-generation (shift-and-add) group. Each cycle it may receive an instruction word, two register operands and a valid strobe. It decodes the word and computes the result. One clock later it presents a registered result, a result-valid flag and an illegal flag.

The unit claims an instruction only when the opcode and funct7 fall into one of its groups. Inside a claimed group, an encoding that names no supported operation is reported as illegal, with a zero result. Encodings outside its groups are left to other units. This includes the base subtract and arithmetic-shift encodings that share funct7 0100000 with the negated logic operations. For these the unit raises neither the valid flag nor the illegal flag. Field positions follow the standard R-type layout: opcode bits 6:0, funct3 bits 14:12, rs2/immediate field bits 24:20, funct7 bits 31:25. Opcode 0010011 is called the immediate opcode and 0110011 the register opcode.

Top module: `bitmanip_unit`

## Requirements
- R1: Every output is registered. When `in_valid` is high with a claimed encoding, `out_valid` is high in the next cycle. When `in_valid` is low, `out_valid` and `out_illegal` are low in the next cycle and `out_result` is zero.
- R2: A synchronous active-high `rst` clears `out_valid`, `out_illegal` and `out_result` at the next clock edge, even when a valid instruction is presented at that edge.
- R3: With the immediate opcode, funct7 0110000 and funct3 001, the rs2 field selects a count. 00000 gives the leading-zero count, 00001 the trailing-zero count and 00010 the number of set bits of operand 1. Both zero counts return 32 for an all-zero operand.
- R4: With the same group as R3, rs2 field 00100 gives operand 1 bits 7:0 sign-extended and 00101 gives bits 15:0 sign-extended. Register opcode, funct7 0000100, funct3 100, rs2 field 00000 gives bits 15:0 zero-extended.
- R5: Register opcode with funct7 0000101 selects by funct3: 100 gives the signed minimum, 101 the unsigned minimum, 110 the signed maximum and 111 the unsigned maximum of the two operands.
- R6: Register opcode with funct7 0100000 selects by funct3: 111 gives op1 AND NOT op2, 110 gives op1 OR NOT op2 and 100 gives op1 XOR NOT op2.
- R7: Register opcode with funct7 0110000 rotates operand 1 left (funct3 001) or right (funct3 101) by operand 2 bits 4:0. Higher bits of operand 2 are ignored, and an amount of 0 returns operand 1 unchanged.
- R8: Immediate opcode, funct7 0110000, funct3 101 rotates operand 1 right by the 5-bit amount held in the rs2 field. Field value 10100 rotates by 20.
- R9: Immediate opcode, funct3 101 with funct7 0010100 and field 00111 sets each result byte to 0xFF when the matching operand 1 byte is non-zero and to 0x00 otherwise. Funct7 0110100 with field 11000 reverses the byte order of operand 1.
- R10: Register opcode with funct7 0010000 gives op2 + (op1 << 1) for funct3 010, op2 + (op1 << 2) for 100 and op2 + (op1 << 3) for 110, all modulo 2^32.
- R11: A valid encoding in any claimed group that matches no listed operation raises `out_illegal` together with `out_valid` for one cycle, with `out_result` zero. The claimed groups are immediate opcode with funct7 0110000, 0010100 or 0110100, and register opcode with funct7 0000100, 0000101, 0100000 (funct3 other than 000 and 101), 0110000 or 0010000.
- R12: A valid encoding outside the claimed groups leaves `out_valid` and `out_illegal` low and `out_result` zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | XLEN | Operand 1 (rs1 value) |
| op_b | input | XLEN | Operand 2 (rs2 value) |
| out_valid | output | 1 | Registered: a claimed instruction completed |
| out_illegal | output | 1 | Registered: claimed group, unsupported encoding |
| out_result | output | XLEN | Registered result, zero when not valid or illegal |

## Verification
The bench builds the unit with the default XLEN of 32. The encodings fix the shift-amount and byte-lane positions to that width, so this is the only width at which every field value in the requirements is meaningful. At this width the bench can reach the 32-result corner of both zero counts, rotates by 0, 31 and by amounts with bit 5 set, carries out of bit 31 in the shift-and-add group, and the signed/unsigned split at 0x80000000. A seeded stream that mixes claimed, illegal and foreign encodings with gaps in the valid strobe is compared against a behavioural model on every clock.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int ILEN = 32;

    localparam logic [6:0] OPC_IMM = 7'b0010011;
    localparam logic [6:0] OPC_REG = 7'b0110011;

    // funct7 groups
    localparam logic [6:0] G_ROT   = 7'b0110000;
    localparam logic [6:0] G_ORC   = 7'b0010100;
    localparam logic [6:0] G_REV   = 7'b0110100;
    localparam logic [6:0] G_ZEXT  = 7'b0000100;
    localparam logic [6:0] G_MINMX = 7'b0000101;
    localparam logic [6:0] G_NLOG  = 7'b0100000;
    localparam logic [6:0] G_SHADD = 7'b0010000;

    typedef enum logic [4:0] {
        K_NONE, K_CLZ, K_CTZ, K_CPOP, K_SEXTB, K_SEXTH, K_ZEXTH,
        K_MIN, K_MINU, K_MAX, K_MAXU, K_ANDN, K_ORN, K_XNOR,
        K_ROL, K_ROR, K_RORI, K_ORCB, K_REV8, K_SH1, K_SH2, K_SH3
    } bmu_kind_e;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
    import bmu_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] fn3,
    input  logic [6:0] fn7,
    input  logic [4:0] fld,
    output bmu_kind_e  kind,
    output logic       claim,
    output logic       bad
);

    always_comb begin
        kind  = K_NONE;
        claim = 1'b0;
        bad   = 1'b0;
        if (opcode == OPC_IMM) begin
            case (fn7)
                G_ROT: begin
                    claim = 1'b1;
                    if (fn3 == 3'b001) begin
                        case (fld)
                            5'b00000: kind = K_CLZ;
                            5'b00001: kind = K_CTZ;
                            5'b00010: kind = K_CPOP;
                            5'b00100: kind = K_SEXTB;
                            5'b00101: kind = K_SEXTH;
                            default:  bad  = 1'b1;
                        endcase
                    end else if (fn3 == 3'b101) begin
                        kind = K_RORI;
                    end else begin
                        bad = 1'b1;
                    end
                end
                G_ORC: begin
                    claim = 1'b1;
                    if (fn3 == 3'b101 && fld == 5'b00111) kind = K_ORCB;
                    else bad = 1'b1;
                end
                G_REV: begin
                    claim = 1'b1;
                    if (fn3 == 3'b101 && fld == 5'b11000) kind = K_REV8;
                    else bad = 1'b1;
                end
                default: ;
            endcase
        end else if (opcode == OPC_REG) begin
            case (fn7)
                G_ZEXT: begin
                    claim = 1'b1;
                    if (fn3 == 3'b100 && fld == 5'b00000) kind = K_ZEXTH;
                    else bad = 1'b1;
                end
                G_MINMX: begin
                    claim = 1'b1;
                    case (fn3)
                        3'b100:  kind = K_MIN;
                        3'b101:  kind = K_MINU;
                        3'b110:  kind = K_MAX;
                        3'b111:  kind = K_MAXU;
                        default: bad  = 1'b1;
                    endcase
                end
                G_NLOG: begin
                    // funct3 000 / 101 belong to the base subtract / arithmetic shift
                    if (fn3 != 3'b000 && fn3 != 3'b101) begin
                        claim = 1'b1;
                        case (fn3)
                            3'b111:  kind = K_ANDN;
                            3'b110:  kind = K_ORN;
                            3'b100:  kind = K_XNOR;
                            default: bad  = 1'b1;
                        endcase
                    end
                end
                G_ROT: begin
                    claim = 1'b1;
                    case (fn3)
                        3'b001:  kind = K_ROL;
                        3'b101:  kind = K_ROR;
                        default: bad  = 1'b1;
                    endcase
                end
                G_SHADD: begin
                    claim = 1'b1;
                    case (fn3)
                        3'b010:  kind = K_SH1;
                        3'b100:  kind = K_SH2;
                        3'b110:  kind = K_SH3;
                        default: bad  = 1'b1;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bmu_bitcount.sv
module bmu_bitcount #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  src,
    output logic [CW-1:0] lead,
    output logic [CW-1:0] trail,
    output logic [CW-1:0] ones
);

    always_comb begin
        lead = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (src[i]) lead = CW'(W - 1 - i);
        end
    end

    always_comb begin
        trail = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (src[i]) trail = CW'(i);
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(src[i]);
        end
    end

endmodule

// File: rtl/bmu_alu.sv
module bmu_alu
    import bmu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  bmu_kind_e       kind,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [SHW-1:0]  imm_amt,
    output logic [XLEN-1:0] y
);

    localparam int NB = XLEN / 8;
    localparam int CW = $clog2(XLEN + 1);

    logic [CW-1:0]     n_lead, n_trail, n_ones;
    logic [XLEN-1:0]   orc_v, rev_v;
    logic [SHW-1:0]    amt;
    logic [2*XLEN-1:0] rl_w, rr_w;
    logic              lt_s, lt_u;

    bmu_bitcount #(.W(XLEN), .CW(CW)) u_cnt (
        .src   (a),
        .lead  (n_lead),
        .trail (n_trail),
        .ones  (n_ones)
    );

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign orc_v[8*g +: 8] = {8{|a[8*g +: 8]}};
        assign rev_v[8*g +: 8] = a[8*(NB-1-g) +: 8];
    end

    assign amt  = (kind == K_RORI) ? imm_amt : b[SHW-1:0];
    assign rl_w = {a, a} << amt;
    assign rr_w = {a, a} >> amt;
    assign lt_s = $signed(a) < $signed(b);
    assign lt_u = a < b;

    always_comb begin
        case (kind)
            K_CLZ:   y = {{(XLEN-CW){1'b0}}, n_lead};
            K_CTZ:   y = {{(XLEN-CW){1'b0}}, n_trail};
            K_CPOP:  y = {{(XLEN-CW){1'b0}}, n_ones};
            K_SEXTB: y = {{(XLEN-8){a[7]}}, a[7:0]};
            K_SEXTH: y = {{(XLEN-16){a[15]}}, a[15:0]};
            K_ZEXTH: y = {{(XLEN-16){1'b0}}, a[15:0]};
            K_MIN:   y = lt_s ? a : b;
            K_MINU:  y = lt_u ? a : b;
            K_MAX:   y = lt_s ? b : a;
            K_MAXU:  y = lt_u ? b : a;
            K_ANDN:  y = a & ~b;
            K_ORN:   y = a | ~b;
            K_XNOR:  y = ~(a ^ b);
            K_ROL:   y = rl_w[2*XLEN-1:XLEN];
            K_ROR,
            K_RORI:  y = rr_w[XLEN-1:0];
            K_ORCB:  y = orc_v;
            K_REV8:  y = rev_v;
            K_SH1:   y = b + (a << 1);
            K_SH2:   y = b + (a << 2);
            K_SH3:   y = b + (a << 3);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
    import bmu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [XLEN-1:0] out_result
);

    localparam int SHW = $clog2(XLEN);

    typedef struct packed {
        logic            vld;
        logic            ill;
        logic [XLEN-1:0] res;
    } stage_t;

    stage_t    st_d, st_q;
    bmu_kind_e kind;
    logic      claim, bad;
    logic [XLEN-1:0] alu_y;

    bmu_decode u_dec (
        .opcode (instr[6:0]),
        .fn3    (instr[14:12]),
        .fn7    (instr[31:25]),
        .fld    (instr[24:20]),
        .kind   (kind),
        .claim  (claim),
        .bad    (bad)
    );

    bmu_alu #(.XLEN(XLEN), .SHW(SHW)) u_alu (
        .kind    (kind),
        .a       (op_a),
        .b       (op_b),
        .imm_amt (instr[20 +: SHW]),
        .y       (alu_y)
    );

    always_comb begin
        st_d.vld = in_valid & claim;
        st_d.ill = in_valid & claim & bad;
        st_d.res = (in_valid & claim & ~bad) ? alu_y : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_illegal = st_q.ill;
    assign out_result  = st_q.res;

endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] op_a,
    input logic [XLEN-1:0] op_b,
    input logic            out_valid,
    input logic            out_illegal,
    input logic [XLEN-1:0] out_result
);

    localparam int SHW = $clog2(XLEN);

    // R2
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_illegal && out_result == '0));

    // R1
    valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R11
    illegal_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_valid);

    // R11
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_result == '0);

    // R3
    clz_of_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(instr[31:20]) == 12'b0110000_00000
                   && $past(instr[14:12]) == 3'b001
                   && $past(instr[6:0]) == 7'b0010011
                   && $past(op_a) == '0)
        |-> out_result == XLEN);

    // R7
    rol_by_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(instr[31:25]) == 7'b0110000
                   && $past(instr[14:12]) == 3'b001
                   && $past(instr[6:0]) == 7'b0110011
                   && $past(op_b[SHW-1:0]) == '0)
        |-> out_result == $past(op_a));

endmodule

bind bitmanip_unit bmu_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .instr       (instr),
    .op_a        (op_a),
    .op_b        (op_b),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_result  (out_result)
);

// File: tb/sim_bitmanip_unit.sv
`timescale 1ns/1ps
module sim_bitmanip_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic        out_illegal;
    logic [31:0] out_result;

    int total = 0;
    int bad   = 0;

    logic        e_v, e_il;
    logic [31:0] e_r;
    string       e_tag;
    bit          have_exp = 0;

    always #2.5 clk = ~clk;

    bitmanip_unit #(.XLEN(32)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
    );

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] fld,
                                        input logic [2:0] f3, input logic [6:0] opc);
        return {f7, fld, 5'd3, f3, 5'd9, opc};
    endfunction

    function automatic int lead0(input logic [31:0] x);
        int n = 0;
        while (n < 32 && !x[31-n]) n++;
        return n;
    endfunction

    function automatic int trail0(input logic [31:0] x);
        int n = 0;
        while (n < 32 && !x[n]) n++;
        return n;
    endfunction

    function automatic int ones(input logic [31:0] x);
        int n = 0;
        for (int i = 0; i < 32; i++) n += int'(x[i]);
        return n;
    endfunction

    function automatic logic [31:0] rotr(input logic [31:0] x, input int s);
        return (x >> s) | (x << ((32 - s) % 32));
    endfunction

    task automatic ref_model(input logic r, input logic v_in, input logic [31:0] ins,
                             input logic [31:0] a, input logic [31:0] b,
                             output logic v, output logic il, output logic [31:0] res,
                             output string tag);
        logic [6:0] opc = ins[6:0];
        logic [6:0] f7  = ins[31:25];
        logic [2:0] f3  = ins[14:12];
        int         fl  = int'(ins[24:20]);
        v = 0; il = 0; res = 0; tag = "R12";
        if (r) begin tag = "R2"; return; end
        if (!v_in) begin tag = "R1"; return; end
        if (opc == 7'b0010011) begin
            if (f7 == 7'b0110000 && f3 == 3'b001) begin
                v = 1; tag = "R3";
                if (fl == 0) res = lead0(a);
                else if (fl == 1) res = trail0(a);
                else if (fl == 2) res = ones(a);
                else if (fl == 4) begin res = {{24{a[7]}}, a[7:0]}; tag = "R4"; end
                else if (fl == 5) begin res = {{16{a[15]}}, a[15:0]}; tag = "R4"; end
                else begin il = 1; tag = "R11"; end
            end else if (f7 == 7'b0110000 && f3 == 3'b101) begin
                v = 1; tag = "R8"; res = rotr(a, fl);
            end else if (f7 == 7'b0110000) begin
                v = 1; il = 1; tag = "R11";
            end else if (f7 == 7'b0010100) begin
                v = 1;
                if (f3 == 3'b101 && fl == 7) begin
                    tag = "R9";
                    for (int k = 0; k < 4; k++) res[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
                end else begin il = 1; tag = "R11"; end
            end else if (f7 == 7'b0110100) begin
                v = 1;
                if (f3 == 3'b101 && fl == 24) begin
                    tag = "R9"; res = {a[7:0], a[15:8], a[23:16], a[31:24]};
                end else begin il = 1; tag = "R11"; end
            end
        end else if (opc == 7'b0110011) begin
            if (f7 == 7'b0000100) begin
                v = 1;
                if (f3 == 3'b100 && fl == 0) begin tag = "R4"; res = {16'h0, a[15:0]}; end
                else begin il = 1; tag = "R11"; end
            end else if (f7 == 7'b0000101) begin
                v = 1; tag = "R5";
                if (f3 == 3'b100) res = ($signed(a) < $signed(b)) ? a : b;
                else if (f3 == 3'b101) res = (a < b) ? a : b;
                else if (f3 == 3'b110) res = ($signed(a) > $signed(b)) ? a : b;
                else if (f3 == 3'b111) res = (a > b) ? a : b;
                else begin il = 1; tag = "R11"; end
            end else if (f7 == 7'b0100000 && f3 != 3'b000 && f3 != 3'b101) begin
                v = 1; tag = "R6";
                if (f3 == 3'b111) res = a & ~b;
                else if (f3 == 3'b110) res = a | ~b;
                else if (f3 == 3'b100) res = a ^ ~b;
                else begin il = 1; tag = "R11"; end
            end else if (f7 == 7'b0110000) begin
                v = 1; tag = "R7";
                if (f3 == 3'b001) res = rotr(a, (32 - int'(b[4:0])) % 32);
                else if (f3 == 3'b101) res = rotr(a, int'(b[4:0]));
                else begin il = 1; tag = "R11"; end
            end else if (f7 == 7'b0010000) begin
                v = 1; tag = "R10";
                if (f3 == 3'b010) res = b + a * 2;
                else if (f3 == 3'b100) res = b + a * 4;
                else if (f3 == 3'b110) res = b + a * 8;
                else begin il = 1; tag = "R11"; end
            end
        end
    endtask

    // one clock: compare previous expectation, then drive the next input
    task automatic step(input logic r, input logic v, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        if (have_exp) begin
            total++;
            if (out_valid !== e_v || out_illegal !== e_il || out_result !== e_r) begin
                bad++;
                $display("FAIL %s: got v=%0b il=%0b r=%08h, expected v=%0b il=%0b r=%08h",
                         e_tag, out_valid, out_illegal, out_result, e_v, e_il, e_r);
            end
        end
        rst = r; in_valid = v; instr = ins; op_a = a; op_b = b;
        ref_model(r, v, ins, a, b, e_v, e_il, e_r, e_tag);
        have_exp = 1;
    endtask

    task automatic go(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        step(1'b0, 1'b1, ins, a, b);
    endtask

    localparam logic [6:0] IM = 7'b0010011;
    localparam logic [6:0] RG = 7'b0110011;

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] pool [16];
        // R2: reset held with a valid instruction in front of it
        step(1'b1, 1'b1, enc(7'b0000101, 5'd0, 3'b111, RG), 32'h1, 32'h2);
        step(1'b1, 1'b1, enc(7'b0000101, 5'd0, 3'b111, RG), 32'h1, 32'h2);
        // R3 counts
        go(enc(7'b0110000, 5'd0, 3'b001, IM), 32'h00F0_0000, 0);
        go(enc(7'b0110000, 5'd0, 3'b001, IM), 32'h0, 0);
        go(enc(7'b0110000, 5'd0, 3'b001, IM), 32'h8000_0000, 0);
        go(enc(7'b0110000, 5'd1, 3'b001, IM), 32'h0000_0100, 0);
        go(enc(7'b0110000, 5'd1, 3'b001, IM), 32'h0, 0);
        go(enc(7'b0110000, 5'd2, 3'b001, IM), 32'hFFFF_FFFF, 0);
        go(enc(7'b0110000, 5'd2, 3'b001, IM), 32'h0F0F_0001, 0);
        // R4 extensions
        go(enc(7'b0110000, 5'd4, 3'b001, IM), 32'h1234_5680, 0);
        go(enc(7'b0110000, 5'd4, 3'b001, IM), 32'hFFFF_FF7F, 0);
        go(enc(7'b0110000, 5'd5, 3'b001, IM), 32'h1234_8000, 0);
        go(enc(7'b0000100, 5'd0, 3'b100, RG), 32'hABCD_9234, 0);
        // R5 min/max at the signed/unsigned split
        for (int f = 4; f < 8; f++) go(enc(7'b0000101, 5'd0, 3'(f), RG), 32'hFFFF_FFFF, 32'h1);
        for (int f = 4; f < 8; f++) go(enc(7'b0000101, 5'd0, 3'(f), RG), 32'h8000_0000, 32'h7FFF_FFFF);
        // R6 negated logic
        go(enc(7'b0100000, 5'd0, 3'b111, RG), 32'hF0F0_FF00, 32'h0FF0_F0F0);
        go(enc(7'b0100000, 5'd0, 3'b110, RG), 32'hF0F0_FF00, 32'h0FF0_F0F0);
        go(enc(7'b0100000, 5'd0, 3'b100, RG), 32'hF0F0_FF00, 32'h0FF0_F0F0);
        // R7 rotates, amount from op_b[4:0] only
        go(enc(7'b0110000, 5'd0, 3'b001, RG), 32'h8765_4321, 32'h0);
        go(enc(7'b0110000, 5'd0, 3'b001, RG), 32'h8765_4321, 32'h1);
        go(enc(7'b0110000, 5'd0, 3'b001, RG), 32'h8765_4321, 32'd31);
        go(enc(7'b0110000, 5'd0, 3'b101, RG), 32'h8765_4321, 32'd37);
        go(enc(7'b0110000, 5'd0, 3'b101, RG), 32'h8765_4321, 32'hFFFF_FFE0);
        // R8 immediate rotate
        go(enc(7'b0110000, 5'd20, 3'b101, IM), 32'h1234_5678, 32'hFFFF_FFFF);
        go(enc(7'b0110000, 5'd0, 3'b101, IM), 32'h1234_5678, 32'd7);
        // R9 byte operations
        go(enc(7'b0010100, 5'd7, 3'b101, IM), 32'h0010_0300, 0);
        go(enc(7'b0010100, 5'd7, 3'b101, IM), 32'h8000_0001, 0);
        go(enc(7'b0110100, 5'd24, 3'b101, IM), 32'h1122_3344, 0);
        // R10 shift-and-add with wrap
        go(enc(7'b0010000, 5'd0, 3'b010, RG), 32'h8000_0003, 32'h10);
        go(enc(7'b0010000, 5'd0, 3'b100, RG), 32'h4000_0001, 32'hFFFF_FFFF);
        go(enc(7'b0010000, 5'd0, 3'b110, RG), 32'h2000_0002, 32'h5);
        // R11 unlisted encodings inside the groups
        go(enc(7'b0110000, 5'd3, 3'b001, IM), 32'hFFFF_FFFF, 0);
        go(enc(7'b0110000, 5'd0, 3'b000, IM), 32'hFFFF_FFFF, 0);
        go(enc(7'b0000100, 5'd1, 3'b100, RG), 32'hFFFF_FFFF, 0);
        go(enc(7'b0000101, 5'd0, 3'b000, RG), 32'h5, 32'h6);
        go(enc(7'b0100000, 5'd0, 3'b001, RG), 32'h5, 32'h6);
        go(enc(7'b0110000, 5'd0, 3'b010, RG), 32'h5, 32'h6);
        go(enc(7'b0010000, 5'd0, 3'b000, RG), 32'h5, 32'h6);
        go(enc(7'b0010100, 5'd6, 3'b101, IM), 32'h5, 0);
        go(enc(7'b0110100, 5'd24, 3'b001, IM), 32'h5, 0);
        // R12 foreign encodings
        go(enc(7'b0000000, 5'd0, 3'b000, RG), 32'h5, 32'h6);
        go(enc(7'b0100000, 5'd0, 3'b000, RG), 32'h5, 32'h6);
        go(enc(7'b0100000, 5'd0, 3'b101, RG), 32'h5, 32'h6);
        go(enc(7'b0110000, 5'd0, 3'b001, 7'b0000011), 32'h5, 32'h6);
        go(enc(7'b0000101, 5'd0, 3'b100, IM), 32'h5, 32'h6);
        // R1: good encoding without strobe
        step(1'b0, 1'b0, enc(7'b0000101, 5'd0, 3'b111, RG), 32'h9, 32'h3);
        // R2: reset in mid-stream
        go(enc(7'b0110100, 5'd24, 3'b101, IM), 32'hDEAD_BEEF, 0);
        step(1'b1, 1'b1, enc(7'b0110100, 5'd24, 3'b101, IM), 32'hDEAD_BEEF, 0);
        // mixed stream
        pool[0]  = enc(7'b0110000, 5'd0, 3'b001, IM);
        pool[1]  = enc(7'b0110000, 5'd1, 3'b001, IM);
        pool[2]  = enc(7'b0110000, 5'd2, 3'b001, IM);
        pool[3]  = enc(7'b0110000, 5'd5, 3'b001, IM);
        pool[4]  = enc(7'b0000100, 5'd0, 3'b100, RG);
        pool[5]  = enc(7'b0000101, 5'd0, 3'b100, RG);
        pool[6]  = enc(7'b0000101, 5'd0, 3'b111, RG);
        pool[7]  = enc(7'b0100000, 5'd0, 3'b110, RG);
        pool[8]  = enc(7'b0110000, 5'd0, 3'b001, RG);
        pool[9]  = enc(7'b0110000, 5'd0, 3'b101, RG);
        pool[10] = enc(7'b0110000, 5'd13, 3'b101, IM);
        pool[11] = enc(7'b0010100, 5'd7, 3'b101, IM);
        pool[12] = enc(7'b0110100, 5'd24, 3'b101, IM);
        pool[13] = enc(7'b0010000, 5'd0, 3'b110, RG);
        pool[14] = enc(7'b0010000, 5'd0, 3'b011, RG);
        pool[15] = enc(7'b0100000, 5'd0, 3'b000, RG);
        seed = 32'h1357_9BDF;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra, rb;
            seed = seed * 32'd1664525 + 32'd1013904223;
            ra = seed ^ {seed[15:0], seed[31:16]};
            if (seed[9:8] == 2'b00) ra = ra & 32'h00FF_0000;
            seed = seed * 32'd1664525 + 32'd1013904223;
            rb = seed;
            step(1'b0, seed[31:29] != 3'b000, pool[seed[27:24]], ra, rb);
        end
        step(1'b0, 1'b0, 0, 0, 0);
        step(1'b0, 1'b0, 0, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule